// File: doc/BRIEF.md
# Multiprocessor UART with Address Filter

This block is a serial transmitter and receiver pair for a shared multidrop bus. Each character carries a ninth bit, the tag. A tag of 1 marks a station address and a tag of 0 marks payload data. A master uses the transmitter to tag every outgoing character. A slave uses the receiver with its filter switched on, so the host sees only address characters until one of them names this station.

When an address matches the station address, the filter drops and the payload that follows is delivered. An address that does not match, a strobe on the end-of-message input or the set strobe raises the filter again. Software controls the filter bit only through dedicated set and clear strobes, which touch no other state. Bit timing comes from an external `bit_tick` pulse, asserted once per bit time and aligned to the middle of the bit. Both halves advance only on that pulse.

Top module: `mpx_uart`

## Requirements
- R1: A received character is a 0 start bit, eight data bits LSB first, the tag bit, then a 1 stop bit, each sampled on a `bit_tick`. An accepted character pulses `rx_valid` for exactly one cycle, two clock edges after the edge that samples the stop bit.
- R2: A character with tag 1 (address) is always delivered on `rx_data` with `rx_tag`=1, whatever the filter state.
- R3: While `filt_mode` is 1, a character with tag 0 (data) is discarded: `rx_valid` stays low and `rx_data` keeps its previous value.
- R4: While `filt_mode` is 0, data characters are delivered with `rx_tag`=0.
- R5: A delivered address sets `filt_mode` to 0 if it equals `station_addr` and to 1 otherwise, including when the station was already selected. The change is visible in the same cycle as the `rx_valid` pulse.
- R6: A one-cycle `msg_end` pulse sets `filt_mode` to 1 on the next edge.
- R7: `filt_set` sets and `filt_clr` clears `filt_mode` on the next edge. `filt_set` or `msg_end` beats `filt_clr`, and an address evaluated on the same edge beats all three strobes. A data character on that edge is judged against the filter value before the edge.
- R8: A stop bit sampled as 0 pulses `rx_ferr` for one cycle, aligned with where `rx_valid` would have been. The character is dropped, and `rx_data` and `filt_mode` are left unchanged.
- R9: A `tx_go` pulse while `tx_busy` is 0 loads `tx_data` and `tx_tag` and raises `tx_busy`. The next 11 `bit_tick`s each put one bit on `txd`: 0, data LSB first, tag, 1. The 12th tick returns the transmitter to idle, with `txd`=1 and `tx_busy`=0. `txd` changes one edge after the sampled tick.
- R10: The filter state has no effect on the transmitter. The same frame is sent with `filt_mode` 0 or 1.
- R11: During reset `txd`=1, `tx_busy`=0, `rx_valid`=0, `rx_ferr`=0, `rx_data`=0 and `filt_mode`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time, mid-bit |
| rxd | input | 1 | Serial line in, synchronous to clk |
| txd | output | 1 | Serial line out, idles high |
| tx_go | input | 1 | Start a transmission |
| tx_data | input | 8 | Byte to send |
| tx_tag | input | 1 | 1 = send as address, 0 = data |
| tx_busy | output | 1 | Transmitter occupied |
| station_addr | input | 8 | This station's address |
| filt_set | input | 1 | Strobe: turn the filter on |
| filt_clr | input | 1 | Strobe: turn the filter off |
| msg_end | input | 1 | Strobe: message finished, filter back on |
| rx_valid | output | 1 | One-cycle pulse: new received character |
| rx_data | output | 8 | Last delivered character |
| rx_tag | output | 1 | Tag bit of the last delivered character |
| rx_ferr | output | 1 | One-cycle pulse: stop bit missing |
| filt_mode | output | 1 | Current filter state |

## Verification
Receive results are due two clock edges after the edge that samples the stop bit: one edge in the deframer and one in the filter stage. Strobe effects on `filt_mode` are due one edge after the strobe is sampled. The bench drives inputs on falling edges and records each stimulus with the exact cycle number at which its result must appear. A per-cycle monitor compares all receive outputs against that schedule, so a pulse that comes one cycle early or late, or a spurious pulse, is reported. Transmit bits are checked on the falling edge after each sampled tick, which is one edge after the transmitter register updates.

// File: rtl/mpx_uart_pkg.sv
`timescale 1ns/1ps
package mpx_uart_pkg;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_DATA,
        RX_TAG,
        RX_STOP
    } rx_st_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_WAIT,
        TX_SHIFT
    } tx_st_e;

endpackage

// File: rtl/mpx_uart_rx.sv
`timescale 1ns/1ps
// Deframer: start, DATA_W bits LSB first, tag, stop. One sample per tick.
module mpx_uart_rx
    import mpx_uart_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              rxd,
    output logic              ch_valid,
    output logic              ch_ferr,
    output logic [DATA_W-1:0] ch_data,
    output logic              ch_tag
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    typedef struct packed {
        rx_st_e            st;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic              tag;
        logic              vld;
        logic              ferr;
    } rx_s;

    localparam rx_s RX_RST = '{st: RX_IDLE, cnt: '0, sh: '0, tag: 1'b0, vld: 1'b0, ferr: 1'b0};

    rx_s rx_d, rx_q;

    always_comb begin
        rx_d      = rx_q;
        rx_d.vld  = 1'b0;
        rx_d.ferr = 1'b0;
        if (bit_tick) begin
            unique case (rx_q.st)
                RX_IDLE: begin
                    if (!rxd) begin
                        rx_d.st  = RX_DATA;
                        rx_d.cnt = '0;
                    end
                end
                RX_DATA: begin
                    rx_d.sh = {rxd, rx_q.sh[DATA_W-1:1]};
                    if (rx_q.cnt == CNT_W'(DATA_W - 1)) begin
                        rx_d.st = RX_TAG;
                    end else begin
                        rx_d.cnt = rx_q.cnt + CNT_W'(1);
                    end
                end
                RX_TAG: begin
                    rx_d.tag = rxd;
                    rx_d.st  = RX_STOP;
                end
                RX_STOP: begin
                    rx_d.vld  = rxd;
                    rx_d.ferr = !rxd;
                    rx_d.st   = RX_IDLE;
                end
                default: rx_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= RX_RST;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign ch_valid = rx_q.vld;
    assign ch_ferr  = rx_q.ferr;
    assign ch_data  = rx_q.sh;
    assign ch_tag   = rx_q.tag;

endmodule

// File: rtl/mpx_uart_filter.sv
`timescale 1ns/1ps
// Station filter and receive holding register.
module mpx_uart_filter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_valid,
    input  logic              ch_ferr,
    input  logic [DATA_W-1:0] ch_data,
    input  logic              ch_tag,
    input  logic [DATA_W-1:0] station_addr,
    input  logic              filt_set,
    input  logic              filt_clr,
    input  logic              msg_end,
    output logic              rx_valid,
    output logic              rx_ferr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_tag,
    output logic              filt_mode
);
    typedef struct packed {
        logic              filt;
        logic              vld;
        logic              ferr;
        logic [DATA_W-1:0] data;
        logic              tag;
    } flt_s;

    localparam flt_s FLT_RST = '{filt: 1'b1, vld: 1'b0, ferr: 1'b0, data: '0, tag: 1'b0};

    flt_s flt_d, flt_q;

    always_comb begin
        flt_d      = flt_q;
        flt_d.vld  = 1'b0;
        flt_d.ferr = ch_ferr;

        // software strobes: raising wins over clearing
        if (filt_set || msg_end) begin
            flt_d.filt = 1'b1;
        end else if (filt_clr) begin
            flt_d.filt = 1'b0;
        end

        if (ch_valid) begin
            if (ch_tag) begin
                // address: always delivered, re-evaluates the selection
                flt_d.vld  = 1'b1;
                flt_d.data = ch_data;
                flt_d.tag  = 1'b1;
                flt_d.filt = (ch_data != station_addr);
            end else if (!flt_q.filt) begin
                flt_d.vld  = 1'b1;
                flt_d.data = ch_data;
                flt_d.tag  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= FLT_RST;
        end else begin
            flt_q <= flt_d;
        end
    end

    assign rx_valid  = flt_q.vld;
    assign rx_ferr   = flt_q.ferr;
    assign rx_data   = flt_q.data;
    assign rx_tag    = flt_q.tag;
    assign filt_mode = flt_q.filt;

endmodule

// File: rtl/mpx_uart_tx.sv
`timescale 1ns/1ps
// Serialiser: waits for a tick, then one bit per tick.
module mpx_uart_tx
    import mpx_uart_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              tx_go,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_tag,
    output logic              txd,
    output logic              tx_busy
);
    localparam int FRAME_W = DATA_W + 3;
    localparam int FCNT_W  = $clog2(FRAME_W);

    typedef struct packed {
        tx_st_e             st;
        logic [FCNT_W-1:0]  cnt;
        logic [FRAME_W-1:0] sh;
        logic               line;
    } tx_s;

    localparam tx_s TX_RST = '{st: TX_IDLE, cnt: '0, sh: '1, line: 1'b1};

    tx_s tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        unique case (tx_q.st)
            TX_IDLE: begin
                tx_d.line = 1'b1;
                if (tx_go) begin
                    tx_d.sh = {1'b1, tx_tag, tx_data, 1'b0};
                    tx_d.st = TX_WAIT;
                end
            end
            TX_WAIT: begin
                if (bit_tick) begin
                    tx_d.st   = TX_SHIFT;
                    tx_d.cnt  = '0;
                    tx_d.line = tx_q.sh[0];
                end
            end
            TX_SHIFT: begin
                if (bit_tick) begin
                    if (tx_q.cnt == FCNT_W'(FRAME_W - 1)) begin
                        tx_d.st   = TX_IDLE;
                        tx_d.line = 1'b1;
                    end else begin
                        tx_d.sh   = {1'b1, tx_q.sh[FRAME_W-1:1]};
                        tx_d.line = tx_q.sh[1];
                        tx_d.cnt  = tx_q.cnt + FCNT_W'(1);
                    end
                end
            end
            default: tx_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= TX_RST;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign txd     = tx_q.line;
    assign tx_busy = (tx_q.st != TX_IDLE);

endmodule

// File: rtl/mpx_uart.sv
`timescale 1ns/1ps
module mpx_uart #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              rxd,
    output logic              txd,
    input  logic              tx_go,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_tag,
    output logic              tx_busy,
    input  logic [DATA_W-1:0] station_addr,
    input  logic              filt_set,
    input  logic              filt_clr,
    input  logic              msg_end,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_tag,
    output logic              rx_ferr,
    output logic              filt_mode
);
    logic              ch_valid;
    logic              ch_ferr;
    logic [DATA_W-1:0] ch_data;
    logic              ch_tag;

    mpx_uart_rx #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .rxd      (rxd),
        .ch_valid (ch_valid),
        .ch_ferr  (ch_ferr),
        .ch_data  (ch_data),
        .ch_tag   (ch_tag)
    );

    mpx_uart_filter #(.DATA_W(DATA_W)) u_filter (
        .clk          (clk),
        .rst_n        (rst_n),
        .ch_valid     (ch_valid),
        .ch_ferr      (ch_ferr),
        .ch_data      (ch_data),
        .ch_tag       (ch_tag),
        .station_addr (station_addr),
        .filt_set     (filt_set),
        .filt_clr     (filt_clr),
        .msg_end      (msg_end),
        .rx_valid     (rx_valid),
        .rx_ferr      (rx_ferr),
        .rx_data      (rx_data),
        .rx_tag       (rx_tag),
        .filt_mode    (filt_mode)
    );

    mpx_uart_tx #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .tx_go    (tx_go),
        .tx_data  (tx_data),
        .tx_tag   (tx_tag),
        .txd      (txd),
        .tx_busy  (tx_busy)
    );

endmodule

// File: rtl/mpx_uart_chk.sv
`timescale 1ns/1ps
module mpx_uart_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              txd,
    input logic              tx_busy,
    input logic [DATA_W-1:0] station_addr,
    input logic              filt_set,
    input logic              filt_clr,
    input logic              msg_end,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_tag,
    input logic              rx_ferr,
    input logic              filt_mode
);
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r3_data_needs_open_filter: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_tag) |-> !$past(filt_mode));

    a_r5_address_decides: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_tag) |-> (filt_mode == (rx_data != $past(station_addr))));

    a_r6_end_raises: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(msg_end) && !(rx_valid && rx_tag)) |-> filt_mode);

    a_r7_clear_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(filt_clr && !filt_set && !msg_end) && !(rx_valid && rx_tag)) |-> !filt_mode);

    a_r8_ferr_excludes_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ferr |-> !rx_valid);

    a_r9_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

endmodule

bind mpx_uart mpx_uart_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .txd          (txd),
    .tx_busy      (tx_busy),
    .station_addr (station_addr),
    .filt_set     (filt_set),
    .filt_clr     (filt_clr),
    .msg_end      (msg_end),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_tag       (rx_tag),
    .rx_ferr      (rx_ferr),
    .filt_mode    (filt_mode)
);

// File: tb/mpx_uart_tb.sv
`timescale 1ns/1ps
module mpx_uart_tb;
    localparam logic [7:0] STN = 8'h5A;
    localparam int K_ACC = 0, K_DROP = 1, K_FERR = 2, K_STRB = 3;

    logic clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b0, rxd = 1'b1;
    logic tx_go = 1'b0, tx_tag = 1'b0, filt_set = 1'b0, filt_clr = 1'b0, msg_end = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic [7:0] station_addr = STN;
    logic txd, tx_busy, rx_valid, rx_tag, rx_ferr, filt_mode;
    logic [7:0] rx_data;

    mpx_uart #(.DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rxd(rxd), .txd(txd),
        .tx_go(tx_go), .tx_data(tx_data), .tx_tag(tx_tag), .tx_busy(tx_busy),
        .station_addr(station_addr), .filt_set(filt_set), .filt_clr(filt_clr),
        .msg_end(msg_end), .rx_valid(rx_valid), .rx_data(rx_data), .rx_tag(rx_tag),
        .rx_ferr(rx_ferr), .filt_mode(filt_mode)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int         due;
        int         kind;
        logic [7:0] data;
        logic       tag;
        logic       filt;
        string      req;
    } ev_t;

    ev_t        evq[$];
    int         cyc = 0;
    int         n_vec = 0;
    int         n_bad = 0;
    bit         mon_on = 1'b0;
    bit         done = 1'b0;
    logic       m_filt = 1'b1;
    logic [7:0] m_data = 8'h00;
    logic       m_tag = 1'b0;
    logic       pend_filt = 1'b1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic push(input int due, input int kind, input logic [7:0] d, input logic tg,
                        input logic nf, input string req);
        ev_t e;
        e.due = due; e.kind = kind; e.data = d; e.tag = tg; e.filt = nf; e.req = req;
        evq.push_back(e);
        pend_filt = nf;
    endtask

    // per-cycle comparison against the scheduled expectations
    always @(negedge clk) begin
        bit    ev_v;
        bit    ev_f;
        string r;
        ev_t   e;
        if (mon_on) begin
            ev_v = 1'b0;
            ev_f = 1'b0;
            r    = "R3";
            if (evq.size() > 0 && evq[0].due == cyc) begin
                e      = evq.pop_front();
                r      = e.req;
                m_filt = e.filt;
                if (e.kind == K_ACC) begin
                    ev_v   = 1'b1;
                    m_data = e.data;
                    m_tag  = e.tag;
                end else if (e.kind == K_FERR) begin
                    ev_f = 1'b1;
                end
            end
            chk(rx_valid === ev_v, r, "rx_valid", rx_valid, ev_v);
            chk(rx_ferr === ev_f, r, "rx_ferr", rx_ferr, ev_f);
            chk(filt_mode === m_filt, r, "filt_mode", filt_mode, m_filt);
            chk(rx_data === m_data, r, "rx_data", rx_data, m_data);
            if (ev_v) chk(rx_tag === m_tag, r, "rx_tag", rx_tag, m_tag);
        end
    end

    task automatic tick_bit(input logic b);
        @(negedge clk); rxd = b; bit_tick = 1'b1;
        @(negedge clk); bit_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // sk: 0 none, 1 set, 2 clear, 3 end-of-message, applied on the filter edge
    task automatic send_frame(input logic [7:0] d, input logic tg, input logic stop,
                              input int sk, input string req);
        int   kind;
        logic nf;
        tick_bit(1'b0);
        for (int i = 0; i < 8; i++) tick_bit(d[i]);
        tick_bit(tg);
        @(negedge clk); rxd = stop; bit_tick = 1'b1;
        nf = pend_filt;
        if (!stop)          kind = K_FERR;
        else if (tg)        kind = K_ACC;
        else if (pend_filt) kind = K_DROP;
        else                kind = K_ACC;
        if (sk == 1 || sk == 3) nf = 1'b1;
        else if (sk == 2)       nf = 1'b0;
        if (stop && tg) nf = (d != STN);
        push(cyc + 2, kind, d, tg, nf, req);
        @(negedge clk); bit_tick = 1'b0;
        filt_set = (sk == 1); filt_clr = (sk == 2); msg_end = (sk == 3);
        @(negedge clk); filt_set = 1'b0; filt_clr = 1'b0; msg_end = 1'b0;
        @(negedge clk);
        tick_bit(1'b1);
    endtask

    task automatic strobe(input logic s, input logic c, input logic en, input string req);
        logic nf;
        @(negedge clk);
        filt_set = s; filt_clr = c; msg_end = en;
        nf = (s || en) ? 1'b1 : (c ? 1'b0 : pend_filt);
        push(cyc + 1, K_STRB, 8'h00, 1'b0, nf, req);
        @(negedge clk);
        filt_set = 1'b0; filt_clr = 1'b0; msg_end = 1'b0;
    endtask

    task automatic tx_frame(input logic [7:0] d, input logic tg, input string req);
        logic [11:0] bits;
        bits = {1'b1, 1'b1, tg, d, 1'b0};
        @(negedge clk); tx_go = 1'b1; tx_data = d; tx_tag = tg;
        @(negedge clk); tx_go = 1'b0;
        chk(tx_busy === 1'b1, req, "tx_busy after go", tx_busy, 1);
        chk(txd === 1'b1, req, "txd before first tick", txd, 1);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); bit_tick = 1'b1;
            @(negedge clk); bit_tick = 1'b0;
            chk(txd === bits[i], req, $sformatf("txd bit %0d", i), txd, bits[i]);
            @(negedge clk);
            @(negedge clk);
        end
        chk(tx_busy === 1'b0, req, "tx_busy after frame", tx_busy, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset values
        chk(txd === 1'b1, "R11", "txd", txd, 1);
        chk(tx_busy === 1'b0, "R11", "tx_busy", tx_busy, 0);
        chk(rx_valid === 1'b0, "R11", "rx_valid", rx_valid, 0);
        chk(rx_ferr === 1'b0, "R11", "rx_ferr", rx_ferr, 0);
        chk(filt_mode === 1'b1, "R11", "filt_mode", filt_mode, 1);
        chk(rx_data === 8'h00, "R11", "rx_data", rx_data, 0);
        rst_n  = 1'b1;
        mon_on = 1'b1;
        tick_bit(1'b1);
        tick_bit(1'b1);

        send_frame(8'h33, 1'b0, 1'b1, 0, "R3");   // filtered data
        send_frame(8'h12, 1'b1, 1'b1, 0, "R2");   // foreign address, still delivered
        send_frame(8'h44, 1'b0, 1'b1, 0, "R3");
        send_frame(STN,   1'b1, 1'b1, 0, "R5");   // selected
        send_frame(8'hA5, 1'b0, 1'b1, 0, "R4");
        send_frame(8'h00, 1'b0, 1'b1, 0, "R1");
        send_frame(8'hFF, 1'b0, 1'b1, 0, "R1");
        send_frame(8'h77, 1'b1, 1'b1, 0, "R5");   // new address ends selection
        send_frame(8'h11, 1'b0, 1'b1, 0, "R3");
        send_frame(STN,   1'b1, 1'b1, 0, "R5");
        send_frame(8'h3C, 1'b0, 1'b1, 0, "R4");
        strobe(1'b0, 1'b0, 1'b1, "R6");           // end of message
        send_frame(8'h66, 1'b0, 1'b1, 0, "R6");
        send_frame(STN,   1'b1, 1'b0, 0, "R8");   // missing stop on an address
        send_frame(8'h81, 1'b0, 1'b0, 0, "R8");
        strobe(1'b0, 1'b1, 1'b0, "R7");
        send_frame(8'h99, 1'b0, 1'b1, 0, "R7");
        strobe(1'b1, 1'b0, 1'b0, "R7");
        strobe(1'b0, 1'b1, 1'b0, "R7");
        strobe(1'b1, 1'b1, 1'b0, "R7");           // set beats clear
        strobe(1'b0, 1'b1, 1'b0, "R7");
        strobe(1'b0, 1'b1, 1'b1, "R7");           // end beats clear
        send_frame(STN,   1'b1, 1'b1, 1, "R7");   // address beats set
        send_frame(8'h01, 1'b1, 1'b1, 2, "R7");   // address beats clear
        send_frame(8'h55, 1'b0, 1'b1, 2, "R7");   // judged on old filter, then cleared
        send_frame(8'h22, 1'b0, 1'b1, 0, "R4");
        send_frame(STN,   1'b1, 1'b0, 3, "R8");   // bad stop, strobe still applies

        tx_frame(8'hC3, 1'b1, "R9");
        strobe(1'b0, 1'b1, 1'b0, "R10");
        tx_frame(8'h3C, 1'b0, "R10");
        strobe(1'b1, 1'b0, 1'b0, "R10");
        tx_frame(8'h3C, 1'b0, "R10");

        repeat (8) @(negedge clk);
        chk(evq.size() == 0, "R1", "pending expectations", evq.size(), 0);
        finish_run();
    end
endmodule